// File: doc/BRIEF.md
# Logical Device Configuration and I/O Range Check Responder

This block holds the configuration state of one logical device on a legacy expansion bus. The state covers the activation bit, the I/O conflict-check control, eight I/O base address registers, two interrupt entries and two DMA channel entries. The host reaches these registers through an index/data interface. It places an 8-bit register index on `cfg_idx`. A write pulse stores `cfg_wdata`, and `cfg_rdata` returns the selected register combinationally.

The block also answers host I/O reads. Each programmed base decodes a window of `SPAN` consecutive ports. An active device answers a hit with its own data. An inactive device with the conflict check enabled answers with a fixed test byte, so the host can detect a second responder on the same ports. When neither case applies, the bus drive enable stays low.

Top module: `ldev_cfg`

## Requirements
- R1: Index 0x30 holds the activation bit in bit 0. Bits 7:1 always read as zero. The `dev_active` output shows the stored bit.
- R2: Index 0x31 holds the check enable in bit 1 and the test byte select in bit 0. Bits 7:2 always read as zero.
- R3: Eight I/O bases lie at indices 0x60 to 0x6F, two bytes per base. For base i, index 0x60+2i holds address bits 15:8 and index 0x61+2i holds bits 7:0. All bits read back as written.
- R4: Two interrupt entries lie at 0x70 to 0x73. Index 0x70+2i holds the level in bits 3:0, with the upper bits reading zero. Index 0x71+2i holds polarity in bit 1 and trigger in bit 0, with bits 7:2 reading zero.
- R5: The DMA entries sit at 0x74 and 0x75. Each keeps bits 2:0, and bits 7:3 read as zero.
- R6: Both `rst_n` low and a `cfg_reset` pulse restore the defaults. Every register goes to zero, except the two DMA entries, which go to 4. A `cfg_reset` in the same cycle as a write wins over the write.
- R7: A bus read hits base i when the base is non-zero and base <= `bus_addr` <= base+SPAN-1, with no wrap past 0xFFFF. A base of zero never hits.
- R8: Take an inactive device with the check enabled. On a hit it drives `bus_drive`=1, with data 0x55 when the select bit is 1 and 0xAA when it is 0.
- R9: An active device drives `dev_rdata` on a hit, whatever the check bits hold.
- R10: In the following cases `bus_drive` is 0 and `bus_rdata` is 0x00: `bus_rd` is low, no base hits, or the device is inactive with the check disabled.
- R11: Indices outside the mapped set read as 0x00. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_reset | input | 1 | Synchronous pulse that restores the defaults |
| cfg_idx | input | 8 | Register index |
| cfg_wr | input | 1 | Write strobe for the indexed register |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of the indexed register |
| bus_addr | input | 16 | Host I/O read address |
| bus_rd | input | 1 | Host I/O read strobe |
| dev_rdata | input | 8 | Data from the device function |
| bus_rdata | output | 8 | Data returned to the host |
| bus_drive | output | 1 | Enable for driving the host data bus |
| dev_active | output | 1 | Activation state |

## Verification
Bus reads are tried at the first and last port of a window, one port below it, one port above it, and inside a window placed at the top of the address space. Together these show whether the span and its bounds are correct and whether the comparison wraps. Each hit is repeated in three states: inactive with the check on, inactive with the check off, and active with the check still on. This separates the priority of the test byte from device data and from silence, and both settings of the select bit show which byte is chosen. Register writes use all-ones data, which exposes any reserved bit that is stored by mistake. A reset pulse applied in the same cycle as a write shows which of the two wins.

// File: rtl/ldev_cfg.sv
module ldev_cfg #(
  parameter int NIO  = 8,
  parameter int NIRQ = 2,
  parameter int NDMA = 2,
  parameter int SPAN = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_reset,
  input  logic [7:0]  cfg_idx,
  input  logic        cfg_wr,
  input  logic [7:0]  cfg_wdata,
  output logic [7:0]  cfg_rdata,
  input  logic [15:0] bus_addr,
  input  logic        bus_rd,
  input  logic [7:0]  dev_rdata,
  output logic [7:0]  bus_rdata,
  output logic        bus_drive,
  output logic        dev_active
);

  localparam logic [16:0] SPAN_W  = 17'(SPAN);
  localparam logic [2:0]  DMA_OFF = 3'd4;

  logic       act, chk_en, chk_sel;
  logic [7:0] io_hi [NIO];
  logic [7:0] io_lo [NIO];
  logic [3:0] irq_lvl [NIRQ];
  logic [1:0] irq_typ [NIRQ];
  logic [2:0] dma_ch [NDMA];

  wire w_act = cfg_wr && cfg_idx == 8'h30;
  wire w_chk = cfg_wr && cfg_idx == 8'h31;
  wire w_io  = cfg_wr && cfg_idx[7:4] == 4'h6;
  wire w_irq = cfg_wr && cfg_idx[7:2] == 6'b011100;
  wire w_dma = cfg_wr && cfg_idx[7:1] == 7'b0111010;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0; chk_en <= 1'b0; chk_sel <= 1'b0;
      for (int i = 0; i < NIO; i++) begin io_hi[i] <= '0; io_lo[i] <= '0; end
      for (int i = 0; i < NIRQ; i++) begin irq_lvl[i] <= '0; irq_typ[i] <= '0; end
      for (int i = 0; i < NDMA; i++) dma_ch[i] <= DMA_OFF;
    end else if (cfg_reset) begin
      act <= 1'b0; chk_en <= 1'b0; chk_sel <= 1'b0;
      for (int i = 0; i < NIO; i++) begin io_hi[i] <= '0; io_lo[i] <= '0; end
      for (int i = 0; i < NIRQ; i++) begin irq_lvl[i] <= '0; irq_typ[i] <= '0; end
      for (int i = 0; i < NDMA; i++) dma_ch[i] <= DMA_OFF;
    end else begin
      if (w_act) act <= cfg_wdata[0];
      if (w_chk) begin chk_en <= cfg_wdata[1]; chk_sel <= cfg_wdata[0]; end
      if (w_io) begin
        if (cfg_idx[0]) io_lo[cfg_idx[3:1]] <= cfg_wdata;
        else            io_hi[cfg_idx[3:1]] <= cfg_wdata;
      end
      if (w_irq) begin
        if (cfg_idx[0]) irq_typ[cfg_idx[1]] <= cfg_wdata[1:0];
        else            irq_lvl[cfg_idx[1]] <= cfg_wdata[3:0];
      end
      if (w_dma) dma_ch[cfg_idx[0]] <= cfg_wdata[2:0];
    end
  end

  always_comb begin
    cfg_rdata = 8'h00;
    if (cfg_idx == 8'h30)
      cfg_rdata = {7'b0, act};
    else if (cfg_idx == 8'h31)
      cfg_rdata = {6'b0, chk_en, chk_sel};
    else if (cfg_idx[7:4] == 4'h6)
      cfg_rdata = cfg_idx[0] ? io_lo[cfg_idx[3:1]] : io_hi[cfg_idx[3:1]];
    else if (cfg_idx[7:2] == 6'b011100)
      cfg_rdata = cfg_idx[0] ? {6'b0, irq_typ[cfg_idx[1]]} : {4'b0, irq_lvl[cfg_idx[1]]};
    else if (cfg_idx[7:1] == 7'b0111010)
      cfg_rdata = {5'b0, dma_ch[cfg_idx[0]]};
  end

  logic [NIO-1:0] hit;
  for (genvar g = 0; g < NIO; g++) begin : g_dec
    wire [16:0] base = {1'b0, io_hi[g], io_lo[g]};
    assign hit[g] = base != 17'd0 && {1'b0, bus_addr} >= base
                    && {1'b0, bus_addr} < base + SPAN_W;
  end

  assign dev_active = act;
  assign bus_drive  = bus_rd && |hit && (act || chk_en);
  assign bus_rdata  = !bus_drive ? 8'h00 : act ? dev_rdata : chk_sel ? 8'h55 : 8'hAA;

  a_r1_act_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_idx == 8'h30 && !cfg_reset) |=> dev_active == $past(cfg_wdata[0]));
  a_r6_reset_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_reset |=> !dev_active && dma_ch[0] == DMA_OFF && dma_ch[1] == DMA_OFF);
  a_r8_test_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_drive && !dev_active) |-> (bus_rdata == 8'h55 || bus_rdata == 8'hAA));
  a_r9_dev_data: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_drive && dev_active) |-> bus_rdata == dev_rdata);
  a_r10_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (!bus_drive && bus_rdata == 8'h00));

endmodule

// File: tb/test_ldev_cfg.sv
`timescale 1ns/1ps
module test_ldev_cfg;
  logic clk = 0, rst_n = 0, cfg_reset = 0, cfg_wr = 0, bus_rd = 0;
  logic [7:0] cfg_idx = 0, cfg_wdata = 0, dev_rdata = 0;
  logic [15:0] bus_addr = 0;
  logic [7:0] cfg_rdata, bus_rdata;
  logic bus_drive, dev_active;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  ldev_cfg i_ldev_cfg (.clk, .rst_n, .cfg_reset, .cfg_idx, .cfg_wr, .cfg_wdata,
    .cfg_rdata, .bus_addr, .bus_rd, .dev_rdata, .bus_rdata, .bus_drive, .dev_active);

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] idx, logic [7:0] d);
    @(negedge clk); cfg_idx = idx; cfg_wdata = d; cfg_wr = 1;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic rdchk(string req, logic [7:0] idx, logic [7:0] exp);
    @(negedge clk); cfg_idx = idx; #0.5;
    chk(req, cfg_rdata, exp);
  endtask

  task automatic buschk(string req, logic [15:0] a, logic rd, logic drv, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = rd; #0.5;
    chk({req, " drive"}, bus_drive, drv);
    chk({req, " data"}, bus_rdata, d);
    bus_rd = 0;
  endtask

  task automatic pulse_reset();
    @(negedge clk); cfg_reset = 1; @(negedge clk); cfg_reset = 0;
  endtask

  task automatic t_defaults(string req);
    rdchk(req, 8'h30, 8'h00); rdchk(req, 8'h31, 8'h00);
    for (int i = 0; i < 16; i++) rdchk(req, 8'h60 + 8'(i), 8'h00);
    for (int i = 0; i < 4; i++) rdchk(req, 8'h70 + 8'(i), 8'h00);
    rdchk(req, 8'h74, 8'h04); rdchk(req, 8'h75, 8'h04);
    chk(req, dev_active, 0);
  endtask

  task automatic t_regs();
    wr(8'h30, 8'hFF); rdchk("R1", 8'h30, 8'h01); chk("R1 out", dev_active, 1);
    wr(8'h30, 8'hFE); rdchk("R1", 8'h30, 8'h00);
    wr(8'h31, 8'hFF); rdchk("R2", 8'h31, 8'h03);
    wr(8'h31, 8'h02); rdchk("R2", 8'h31, 8'h02);
    for (int i = 0; i < 8; i++) begin
      wr(8'h60 + 8'(2*i), 8'(i + 1)); wr(8'h61 + 8'(2*i), 8'(16*i + 3));
    end
    for (int i = 0; i < 8; i++) begin
      rdchk("R3 hi", 8'h60 + 8'(2*i), 8'(i + 1));
      rdchk("R3 lo", 8'h61 + 8'(2*i), 8'(16*i + 3));
    end
    wr(8'h70, 8'hFF); wr(8'h71, 8'hFF); wr(8'h72, 8'h05); wr(8'h73, 8'h02);
    rdchk("R4", 8'h70, 8'h0F); rdchk("R4", 8'h71, 8'h03);
    rdchk("R4", 8'h72, 8'h05); rdchk("R4", 8'h73, 8'h02);
    wr(8'h74, 8'hFF); wr(8'h75, 8'h01);
    rdchk("R5", 8'h74, 8'h07); rdchk("R5", 8'h75, 8'h01);
  endtask

  task automatic t_unmapped();
    wr(8'h40, 8'hAB); wr(8'h32, 8'hFF); wr(8'h76, 8'hFF); wr(8'h2F, 8'hFF);
    rdchk("R11", 8'h40, 8'h00); rdchk("R11", 8'h32, 8'h00);
    rdchk("R11", 8'h76, 8'h00); rdchk("R11", 8'h2F, 8'h00);
    rdchk("R11", 8'h30, 8'h00); rdchk("R11", 8'h31, 8'h02);
    rdchk("R11", 8'h74, 8'h07); rdchk("R11", 8'h75, 8'h01);
  endtask

  task automatic t_reset_pulse();
    pulse_reset(); t_defaults("R6 pulse");
    @(negedge clk); cfg_idx = 8'h30; cfg_wdata = 8'h01; cfg_wr = 1; cfg_reset = 1;
    @(negedge clk); cfg_wr = 0; cfg_reset = 0;
    rdchk("R6 priority", 8'h30, 8'h00);
  endtask

  task automatic t_bus();
    pulse_reset();
    wr(8'h60, 8'h02); wr(8'h61, 8'h20);
    wr(8'h62, 8'hFF); wr(8'h63, 8'hFC);
    wr(8'h31, 8'h03);
    buschk("R8 first", 16'h0220, 1, 1, 8'h55);
    buschk("R8 last", 16'h0227, 1, 1, 8'h55);
    buschk("R7 above", 16'h0228, 1, 0, 8'h00);
    buschk("R7 below", 16'h021F, 1, 0, 8'h00);
    buschk("R7 zero base", 16'h0003, 1, 0, 8'h00);
    buschk("R7 top", 16'hFFFF, 1, 1, 8'h55);
    buschk("R7 nowrap", 16'h0002, 1, 0, 8'h00);
    wr(8'h31, 8'h02);
    buschk("R8 AA", 16'h0224, 1, 1, 8'hAA);
    buschk("R10 no rd", 16'h0224, 0, 0, 8'h00);
    wr(8'h31, 8'h00);
    buschk("R10 chk off", 16'h0224, 1, 0, 8'h00);
    wr(8'h31, 8'h03); wr(8'h30, 8'h01); dev_rdata = 8'h3C;
    buschk("R9 active", 16'h0221, 1, 1, 8'h3C);
    dev_rdata = 8'hC5;
    buschk("R9 top", 16'hFFFD, 1, 1, 8'hC5);
    buschk("R10 miss", 16'h0300, 1, 0, 8'h00);
  endtask

  initial begin
    #12 rst_n = 1;
    t_defaults("R6 reset");
    buschk("R10 reset", 16'h0000, 1, 0, 8'h00);
    t_regs();
    t_unmapped();
    t_reset_pulse();
    t_bus();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #500000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule